// File: doc/BRIEF.md
# Synthesizer Channel Tuner with VCO Calibration Sweep

This block programs a radio frequency synthesizer over a write-only register path. Each setting leaves the block as one 24-bit word, which holds a 4-bit register address above a 20-bit value. The word goes to an external serial shifter through a valid/ready handshake. Tuning to one of fourteen channels always takes three words. The first sets the synthesizer word, the second the fractional divide ratio and the third the VCO configuration. All per-channel values come from lookup logic inside the block.

After reset the block runs a calibration sweep on channel 1. It walks through eleven standard VCO tables and watches a PLL-lock input for a programmable window after each VCO write. When lock is seen, the block keeps the table that follows the locking table for all later tuning. If the lock came on the last table, or no table locked at all, it switches to a fallback mode. In that mode the VCO value is fixed and the synthesizer words are different. After the sweep, the block accepts channel-change requests, reports each finished sequence with a one-cycle done pulse, and flags a bad channel number with an error pulse.

Top module: `rf_tune_seq`

## Requirements
- R1: Every word has its register address in bits [23:20] and its data in bits [19:0]. A tuning sequence sends address 1, then 2, then 3. Each word is held stable on `wr_word`, with `wr_valid` high, until the cycle in which `wr_ready` is high.
- R2: In standard mode the address-1 data is 0x00047 for channels 1–2, 0x00067 for 3–6, 0x00057 for 7–10, 0x00077 for 11–13 and 0x0004F for 14.
- R3: The address-2 data is the same in both modes. It is 0x00CCC for channel 14. For the other channels it follows (channel−1) mod 4: 0 gives 0x00999, 1 gives 0x0099B, 2 gives 0x00998 and 3 gives 0x0099A.
- R4: In standard mode the address-3 data is {4'h4, hi, lo}, where the table t is in 0..10 and the pair p=(channel−1)/2 is in 0..6. hi is 0x60 when p=1, 0x64 when p is 3 or 5, and 0x66 otherwise. lo is entry t+3−p/2 of the list 65,55,75,4D,6D,5D,7D,43,63,53,73,4B,6B,5B.
- R5: After reset the block tunes channel 1 with tables 0,1,… in order. After table t's address-3 word is accepted, `pll_lock` is sampled on the next W rising edges, where W=`lock_window` and 0 counts as 1. A miss moves on to table t+1.
- R6: Lock seen with table k<10 sets `vco_sel` to k+1 with `autocal` low. Lock on table 10, or no lock on any table, sets `autocal` high.
- R7: In fallback mode the address-1 data is 0x06800 plus the R2 value, and the address-3 data is 0x06662 for every channel.
- R8: A request while idle with a channel outside 1–14 raises `err` for exactly the following cycle and sends no word.
- R9: `busy` is high from reset release through the sweep and through each tuning sequence. Requests made while busy are ignored and cause no words.
- R10: `done` is high for one cycle, in the cycle after the last address-3 word of a tuning sequence is accepted, and in the cycle after the sweep decides. `busy` drops in the following cycle.
- R11: While reset is held, `wr_valid`, `done`, `err` and `autocal` are low and `vco_sel` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_req_valid | input | 1 | Channel-change request strobe |
| chan_req_num | input | 4 | Requested channel, valid 1..14 |
| lock_window | input | TMR_W | Lock sampling window in cycles (0 acts as 1) |
| pll_lock | input | 1 | PLL lock indication |
| wr_ready | input | 1 | Shifter accepts the current word |
| wr_valid | output | 1 | Word on `wr_word` is valid |
| wr_word | output | 24 | Address and data word |
| busy | output | 1 | Sweep or tuning sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle bad-channel pulse |
| autocal | output | 1 | Fallback VCO mode selected |
| vco_sel | output | 4 | Selected standard VCO table |

## Verification
The hardest situations to reach are a lock that arrives on the very last edge of the sampling window and a lock that arrives one edge too late. Either one decides whether the sweep keeps a table or drops into fallback mode. The bench counts the accepted address-3 words during the sweep. It raises a single-cycle lock pulse at a chosen edge after the n-th of those words, so it can place lock exactly at edge W and at edge W+1. Other runs lock on the last table and use a zero window. During all of these runs the shifter's ready line stalls every third cycle, so that word holding is exercised throughout.

// File: rtl/rf_tune_pkg.sv
// Package: shared constants, state type and the computed lookup functions
// for synthesizer, divide-ratio and VCO-configuration data.
// Assumes channel numbers 1..NUM_CHAN and VCO tables 0..NUM_VCO_TBL-1.
package rf_tune_pkg;

    localparam int NUM_CHAN    = 14;
    localparam int NUM_VCO_TBL = 11;
    localparam int ADDR_W      = 4;
    localparam int DATA_W      = 20;
    localparam int WORD_W      = ADDR_W + DATA_W;
    localparam int CHAN_W      = $clog2(NUM_CHAN + 1);
    localparam int TBL_W       = $clog2(NUM_VCO_TBL);
    localparam int SLOTS       = 3;

    typedef enum logic [2:0] {
        ST_BOOT, ST_IDLE, ST_SEND, ST_WAIT, ST_DONE
    } seq_state_t;

    // Standard synthesizer low byte, grouped by channel range.
    function automatic logic [7:0] synth_lo(input logic [CHAN_W-1:0] ch);
        if (ch <= 2)       return 8'h47;
        else if (ch <= 6)  return 8'h67;
        else if (ch <= 10) return 8'h57;
        else if (ch <= 13) return 8'h77;
        else               return 8'h4F;
    endfunction

    // Fractional divide ratio: four-channel cycle, last channel special.
    function automatic logic [11:0] div_ratio(input logic [CHAN_W-1:0] ch);
        logic [CHAN_W-1:0] m;
        m = ch - 1'b1;
        if (ch == CHAN_W'(NUM_CHAN)) return 12'hCCC;
        case (m[1:0])
            2'd0:    return 12'h999;
            2'd1:    return 12'h99B;
            2'd2:    return 12'h998;
            default: return 12'h99A;
        endcase
    endfunction

    // VCO entry: each table is the previous one shifted along a shared list.
    function automatic logic [15:0] vco_entry(input logic [TBL_W-1:0] tbl,
                                              input logic [2:0] pair);
        logic [7:0] hi, lo;
        logic [4:0] idx;
        idx = 5'(tbl) + 5'd3 - 5'(pair >> 1);
        if (pair == 3'd1)  hi = 8'h60;
        else if (pair[0])  hi = 8'h64;
        else               hi = 8'h66;
        case (idx)
            5'd0:  lo = 8'h65;  5'd1:  lo = 8'h55;  5'd2:  lo = 8'h75;
            5'd3:  lo = 8'h4D;  5'd4:  lo = 8'h6D;  5'd5:  lo = 8'h5D;
            5'd6:  lo = 8'h7D;  5'd7:  lo = 8'h43;  5'd8:  lo = 8'h63;
            5'd9:  lo = 8'h53;  5'd10: lo = 8'h73;  5'd11: lo = 8'h4B;
            5'd12: lo = 8'h6B;  default: lo = 8'h5B;
        endcase
        return {hi, lo};
    endfunction

endpackage

// File: rtl/rf_tune_rom.sv
// Lookup stage: turns channel, VCO table and mode into the three 20-bit data
// fields. Purely combinational; assumes chan is already range-checked.
module rf_tune_rom
    import rf_tune_pkg::*;
(
    input  logic [CHAN_W-1:0] chan,
    input  logic [TBL_W-1:0]  tbl,
    input  logic              autocal,
    output logic [DATA_W-1:0] synth_data,
    output logic [DATA_W-1:0] div_data,
    output logic [DATA_W-1:0] vco_data
);
    localparam logic [DATA_W-1:0] AC_VCO   = 20'h06662;
    localparam logic [7:0]        AC_SYNTH = 8'h68;

    logic [CHAN_W-1:0] chm1;
    logic [2:0]        pair;

    // Pair index from channel number.
    always_comb begin
        chm1 = chan - 1'b1;
        pair = chm1[3:1];
    end

    // Data selection for the three register slots.
    always_comb begin
        synth_data = autocal ? {4'h0, AC_SYNTH, synth_lo(chan)}
                             : {12'h000, synth_lo(chan)};
        div_data   = {8'h00, div_ratio(chan)};
        vco_data   = autocal ? AC_VCO : {4'h4, vco_entry(tbl, pair)};
    end
endmodule

// File: rtl/rf_word_fmt.sv
// Word packer: picks the data field for the current slot and prefixes the
// register address (slot 0 -> address 1, slot 1 -> 2, slot 2 -> 3).
module rf_word_fmt
    import rf_tune_pkg::*;
(
    input  logic [1:0]        slot,
    input  logic [DATA_W-1:0] d_synth,
    input  logic [DATA_W-1:0] d_div,
    input  logic [DATA_W-1:0] d_vco,
    output logic [WORD_W-1:0] word
);
    logic [DATA_W-1:0] data;
    logic [ADDR_W-1:0] addr;

    // Slot to address and data mux.
    always_comb begin
        addr = ADDR_W'(slot) + 1'b1;
        case (slot)
            2'd0:    data = d_synth;
            2'd1:    data = d_div;
            default: data = d_vco;
        endcase
        word = {addr, data};
    end
endmodule

// File: rtl/rf_lock_timer.sv
// Lock window counter: counts cycles while run is high, clears otherwise.
// expired is high in the run cycle that is the last of the window.
module rf_lock_timer #(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [TMR_W-1:0] limit,
    output logic             expired
);
    logic [TMR_W-1:0] cnt;
    logic [TMR_W:0]   lim_eff;

    // Elapsed-cycle counter, cleared whenever not waiting.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (run) cnt <= cnt + 1'b1;
        else          cnt <= '0;
    end

    // Window end detect; a zero limit behaves as one cycle.
    always_comb begin
        lim_eff = (limit == '0) ? (TMR_W+1)'(1) : {1'b0, limit};
        expired = run && (({1'b0, cnt} + 1'b1) >= lim_eff);
    end
endmodule

// File: rtl/rf_tune_seq.sv
// Top: calibration sweep and channel tuning sequencer. Sweeps the VCO
// tables on channel 1 after reset, keeps the table after the first lock (or
// falls back to fixed-VCO mode), then serves channel requests. Assumes the
// downstream shifter holds wr_ready meaningful only while wr_valid is high.
module rf_tune_seq
    import rf_tune_pkg::*;
#(
    parameter int TMR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chan_req_valid,
    input  logic [CHAN_W-1:0] chan_req_num,
    input  logic [TMR_W-1:0]  lock_window,
    input  logic              pll_lock,
    input  logic              wr_ready,
    output logic              wr_valid,
    output logic [WORD_W-1:0] wr_word,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              autocal,
    output logic [TBL_W-1:0]  vco_sel
);
    localparam logic [TBL_W-1:0] LAST_TBL  = TBL_W'(NUM_VCO_TBL - 1);
    localparam logic [1:0]       LAST_SLOT = 2'(SLOTS - 1);
    localparam logic [CHAN_W-1:0] CAL_CHAN = CHAN_W'(1);

    seq_state_t        state;
    logic [1:0]        slot;
    logic [CHAN_W-1:0] chan_q;
    logic              cal_q;
    logic [TBL_W-1:0]  cal_tbl;
    logic [TBL_W-1:0]  sel_q;
    logic              ac_q;
    logic              err_q;
    logic              chan_ok;
    logic              accept;
    logic              expired;
    logic [TBL_W-1:0]  tbl_use;
    logic [DATA_W-1:0] d_synth, d_div, d_vco;

    // Request range check, handshake and table choice.
    always_comb begin
        chan_ok = (chan_req_num >= CHAN_W'(1)) && (chan_req_num <= CHAN_W'(NUM_CHAN));
        accept  = wr_valid && wr_ready;
        tbl_use = cal_q ? cal_tbl : sel_q;
    end

    rf_tune_rom u_rom (
        .chan       (chan_q),
        .tbl        (tbl_use),
        .autocal    (ac_q),
        .synth_data (d_synth),
        .div_data   (d_div),
        .vco_data   (d_vco)
    );

    rf_word_fmt u_fmt (
        .slot    (slot),
        .d_synth (d_synth),
        .d_div   (d_div),
        .d_vco   (d_vco),
        .word    (wr_word)
    );

    rf_lock_timer #(.TMR_W(TMR_W)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state == ST_WAIT),
        .limit   (lock_window),
        .expired (expired)
    );

    // Sequencer: sweep, lock decision, tuning and request handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_BOOT;
            slot    <= '0;
            chan_q  <= CAL_CHAN;
            cal_q   <= 1'b0;
            cal_tbl <= '0;
            sel_q   <= '0;
            ac_q    <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            err_q <= 1'b0;
            case (state)
                ST_BOOT: begin
                    cal_q   <= 1'b1;
                    cal_tbl <= '0;
                    chan_q  <= CAL_CHAN;
                    slot    <= '0;
                    state   <= ST_SEND;
                end
                ST_IDLE: begin
                    if (chan_req_valid) begin
                        if (chan_ok) begin
                            chan_q <= chan_req_num;
                            slot   <= '0;
                            state  <= ST_SEND;
                        end else begin
                            err_q <= 1'b1;
                        end
                    end
                end
                ST_SEND: begin
                    if (accept) begin
                        if (slot == LAST_SLOT) begin
                            slot  <= '0;
                            state <= cal_q ? ST_WAIT : ST_DONE;
                        end else begin
                            slot <= slot + 1'b1;
                        end
                    end
                end
                ST_WAIT: begin
                    if (pll_lock) begin
                        if (cal_tbl == LAST_TBL) ac_q  <= 1'b1;
                        else                     sel_q <= cal_tbl + 1'b1;
                        cal_q <= 1'b0;
                        state <= ST_DONE;
                    end else if (expired) begin
                        if (cal_tbl == LAST_TBL) begin
                            ac_q  <= 1'b1;
                            cal_q <= 1'b0;
                            state <= ST_DONE;
                        end else begin
                            cal_tbl <= cal_tbl + 1'b1;
                            state   <= ST_SEND;
                        end
                    end
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Output flags.
    always_comb begin
        wr_valid = (state == ST_SEND);
        busy     = (state != ST_IDLE);
        done     = (state == ST_DONE);
        err      = err_q;
        autocal  = ac_q;
        vco_sel  = sel_q;
    end
endmodule

// File: rtl/rf_tune_seq_chk.sv
// Checker: port-level temporal properties of the tuning sequencer,
// attached to every rf_tune_seq instance by the bind below.
module rf_tune_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_valid,
    input logic        wr_ready,
    input logic [23:0] wr_word,
    input logic        busy,
    input logic        done,
    input logic        err,
    input logic        autocal
);
    assert_word_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_word));

    assert_addr_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_word[23:20] >= 4'd1) && (wr_word[23:20] <= 4'd3));

    assert_fixed_vco_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && autocal && (wr_word[23:20] == 4'd3) |-> wr_word[19:0] == 20'h06662);

    assert_err_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !busy && !wr_valid);

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !wr_valid);

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done));
endmodule

bind rf_tune_seq rf_tune_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .wr_word  (wr_word),
    .busy     (busy),
    .done     (done),
    .err      (err),
    .autocal  (autocal)
);

// File: tb/test_rf_tune_seq.sv
// Bench: behavioural model with a queue of expected words, compared on every
// accepted handshake, plus timing checks of busy, done, err and lock window.
module test_rf_tune_seq;
    localparam int CLK_PERIOD = 10;
    localparam int TMR_W      = 16;
    localparam int NT         = 11;

    localparam int SYN [14] = '{'h47,'h47,'h67,'h67,'h67,'h67,'h57,'h57,'h57,'h57,'h77,'h77,'h77,'h4F};
    localparam int DIV [14] = '{'h999,'h99B,'h998,'h99A,'h999,'h99B,'h998,'h99A,'h999,'h99B,'h998,'h99A,'h999,'hCCC};
    localparam int LOL [14] = '{'h65,'h55,'h75,'h4D,'h6D,'h5D,'h7D,'h43,'h63,'h53,'h73,'h4B,'h6B,'h5B};

    logic clk = 0, rst_n = 0;
    logic chan_req_valid = 0;
    logic [3:0] chan_req_num = 0;
    logic [TMR_W-1:0] lock_window = 4;
    logic pll_lock = 0, wr_ready = 0;
    logic wr_valid, busy, done, err, autocal;
    logic [23:0] wr_word;
    logic [3:0] vco_sel;

    int n_tests = 0, n_fail = 0;
    int cyc = 0, hs_total = 0, last_hs = 0;
    int cal_n = 0, lock_tgt = 0, lock_at = 0, lk_wait = -1;
    bit in_cal = 0;
    logic [23:0] exp_q[$];

    rf_tune_seq #(.TMR_W(TMR_W)) i_rf_tune_seq (.*);

    initial forever #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [23:0] ref_word(input int r, input int ch, input int t, input bit ac);
        int p, hi;
        logic [19:0] d;
        p = (ch - 1) / 2;
        hi = (p == 1) ? 'h60 : ((p % 2) == 1 ? 'h64 : 'h66);
        if (r == 1)      d = ac ? 20'(('h68 << 8) + SYN[ch-1]) : 20'(SYN[ch-1]);
        else if (r == 2) d = 20'(DIV[ch-1]);
        else             d = ac ? 20'h06662 : 20'(('h4 << 16) + (hi << 8) + LOL[t + 3 - p/2]);
        return {4'(r), d};
    endfunction

    function automatic string tag_of(input logic [23:0] w);
        if ((w[23:20] == 3 && w[19:0] == 20'h06662) || (w[23:20] == 1 && w[15:8] == 8'h68)) return "R7";
        if (w[23:20] == 1) return "R2";
        if (w[23:20] == 2) return "R3";
        return "R4";
    endfunction

    // Ready stall pattern, driven just after the rising edge.
    initial begin
        int rc = 0;
        forever begin
            @(posedge clk); #1;
            rc++;
            wr_ready = (rc % 3) != 0;
        end
    end

    // Monitor: count cycles, compare every accepted word with the model.
    initial forever begin
        @(negedge clk);
        cyc++;
        if (rst_n && wr_valid && wr_ready) begin
            hs_total++;
            last_hs = cyc;
            if (exp_q.size() == 0) begin
                check(0, "R9", "unexpected word", wr_word, 0);
            end else begin
                logic [23:0] e;
                e = exp_q.pop_front();
                check(wr_word == e, (wr_word[23:20] != e[23:20]) ? "R1" : tag_of(e), "word", wr_word, e);
            end
        end
    end

    // Lock responder: one-cycle lock pulse at edge lock_at after the
    // lock_tgt-th accepted address-3 word of the sweep.
    initial forever begin
        @(negedge clk);
        if (rst_n && in_cal && wr_valid && wr_ready && wr_word[23:20] == 4'd3) begin
            cal_n++;
            if (cal_n == lock_tgt) lk_wait = lock_at - 1;
        end
        @(posedge clk); #1;
        if (lk_wait == 0) begin pll_lock = 1; lk_wait = -1; end
        else begin pll_lock = 0; if (lk_wait > 0) lk_wait--; end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    task automatic wait_done(output int at);
        at = -1;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk); #1;
            if (done) begin at = cyc; break; end
        end
        if (at < 0) check(0, "R10", "done never seen", 0, 1);
    endtask

    task automatic run_cal(input int tgt, input int at_i);
        int win, ntry, dc;
        bit hit, ac;
        win = (lock_window == 0) ? 1 : int'(lock_window);
        hit = (tgt >= 1) && (tgt <= NT) && (at_i >= 1) && (at_i <= win);
        ntry = hit ? tgt : NT;
        ac = !hit || (tgt == NT);
        @(posedge clk); #1;
        rst_n = 0; in_cal = 1; cal_n = 0; lock_tgt = tgt; lock_at = at_i; lk_wait = -1;
        exp_q.delete();
        repeat (2) @(posedge clk);
        @(negedge clk); #1;
        check(!wr_valid && !done && !err && !autocal && vco_sel == 0, "R11", "reset outputs",
              {wr_valid, done, err, autocal, vco_sel}, 0);
        for (int t = 0; t < ntry; t++)
            for (int r = 1; r <= 3; r++) exp_q.push_back(ref_word(r, 1, t, 0));
        @(posedge clk); #1; rst_n = 1;
        @(negedge clk); #1;
        check(busy, "R9", "busy after reset", busy, 1);
        wait_done(dc);
        check(dc - last_hs == (hit ? at_i + 1 : win + 1), "R5", "lock window timing", dc - last_hs,
              hit ? at_i + 1 : win + 1);
        check(exp_q.size() == 0, "R5", "sweep words left", exp_q.size(), 0);
        check(autocal == ac, "R6", "fallback mode", autocal, ac);
        if (!ac) check(vco_sel == 4'(tgt), "R6", "kept table", vco_sel, tgt);
        @(negedge clk); #1;
        check(!done && !busy, "R10", "done single cycle", {done, busy}, 0);
        in_cal = 0;
    endtask

    task automatic tune(input int ch, input int sel, input bit ac, input bit poke);
        int h0;
        bit seen;
        h0 = hs_total;
        for (int r = 1; r <= 3; r++) exp_q.push_back(ref_word(r, ch, sel, ac));
        @(posedge clk); #1; chan_req_valid = 1; chan_req_num = 4'(ch);
        @(posedge clk); #1; chan_req_valid = 0;
        @(negedge clk); #1;
        check(busy, "R9", "busy during tuning", busy, 1);
        if (poke) begin
            @(posedge clk); #1; chan_req_valid = 1; chan_req_num = (ch == 1) ? 4'd5 : 4'd1;
            @(posedge clk); #1; chan_req_valid = 0;
        end
        seen = 0;
        for (int i = 0; i < 200; i++) begin
            if (hs_total >= h0 + 3) begin seen = 1; break; end
            @(negedge clk); #1;
        end
        check(seen, "R1", "three words sent", hs_total - h0, 3);
        @(negedge clk); #1;
        check(done && busy, "R10", "done after last word", {done, busy}, 3);
        @(negedge clk); #1;
        check(!done && !busy, "R10", "back to idle", {done, busy}, 0);
        repeat (4) @(negedge clk);
        #1;
        check(hs_total == h0 + 3 && exp_q.size() == 0, "R9", "no extra words", hs_total - h0, 3);
    endtask

    task automatic bad_req(input int ch);
        int h0;
        h0 = hs_total;
        @(posedge clk); #1; chan_req_valid = 1; chan_req_num = 4'(ch);
        @(posedge clk); #1; chan_req_valid = 0;
        @(negedge clk); #1;
        check(err && !busy, "R8", "error pulse", {err, busy}, 2);
        @(negedge clk); #1;
        check(!err, "R8", "error single cycle", err, 0);
        repeat (3) @(negedge clk);
        #1;
        check(hs_total == h0, "R8", "no words on bad channel", hs_total - h0, 0);
    endtask

    initial begin
        lock_window = 4;
        run_cal(3, 2);
        tune(1, 3, 0, 0);
        tune(8, 3, 0, 1);
        tune(14, 3, 0, 0);
        tune(4, 3, 0, 0);
        bad_req(0);
        bad_req(15);
        run_cal(5, 4);
        tune(12, 5, 0, 0);
        tune(6, 5, 0, 0);
        run_cal(2, 5);
        tune(1, 0, 1, 0);
        tune(14, 0, 1, 0);
        tune(3, 0, 1, 1);
        run_cal(11, 1);
        tune(7, 0, 1, 0);
        lock_window = 0;
        run_cal(1, 1);
        tune(2, 1, 0, 0);
        tune(13, 1, 0, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule